// File: doc/BRIEF.md
# Lockable SMM Base RAM Window Control Register

This block is a single configuration register that lets boot firmware find out whether a small protected RAM window at the fixed SMM base address is available, and then switch that window on permanently. Firmware first writes the query code; the register answers by reading back a "present" code. Firmware then writes the lock bit. From that point the register is frozen until reset, and two enables go high. The first enable makes ordinary (non-SMM) accesses to the window land in a blackhole. The second enable makes the RAM behind the window visible to SMM accesses only.

Until a query has been made, the register discards every written value and reads back zero, so a stray write cannot arm the window. The feature as a whole is chosen by the parameter `FEATURE_EN`. With it cleared, the register ignores writes, reads zero and holds both enables low. A small responder answers reads that the surrounding decoder steers into the blackhole. Each such read is answered with all ones over a valid/ready pair. A response is held until the requester accepts it, and a new request is accepted only when the response slot is empty or is being drained in the same cycle. The configuration write port is a valid/ready pair whose ready is always high, so writes never see back-pressure. All registers use a synchronous, active-low reset.

Top module: `smbase_lock_reg`

## Requirements
- R1: After reset the register reads 0x00, both enables are low, no blackhole response is pending, and the write port's ready is high.
- R2: While no query has been made since reset, any written value other than 0xFF is discarded. The register keeps reading 0x00, and a write of 0x02 does not lock.
- R3: A write of 0xFF while no query is pending makes the register read 0x01 ("present") from the next cycle onward.
- R4: After a query, writes with bit 1 clear leave the register reading 0x01 and the enables low; the other bits are masked off.
- R5: After a query, a write with bit 1 set makes the register read 0x02 and raises both the blackhole enable and the SMM window enable in the next cycle.
- R6: Once locked, every write is ignored. The register keeps reading 0x02 and both enables stay high until reset.
- R7: With `FEATURE_EN` = 0 the register always reads 0x00 and both enables stay low, whatever is written.
- R8: A blackhole read request accepted in one cycle yields a response in the next cycle with every data bit set to one. An unaccepted response stays valid with the same data.
- R9: Reset at any point of the sequence returns the block to the R1 state, so the query must be repeated before a lock takes effect.
- R10: The configuration write port never applies back-pressure: `cfg_wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_ready | output | 1 | Always high; writes are never stalled |
| cfg_wr_data | input | DATA_W | Value written to the register |
| cfg_rd_data | output | DATA_W | Current register value (0x00, 0x01 or 0x02) |
| bh_en | output | 1 | Blackhole enable for non-SMM accesses to the window |
| smm_win_en | output | 1 | RAM window enable for SMM accesses |
| bh_req_valid | input | 1 | Blackhole read request valid |
| bh_req_ready | output | 1 | Blackhole read request ready |
| bh_rsp_valid | output | 1 | Blackhole read response valid |
| bh_rsp_ready | input | 1 | Blackhole read response ready |
| bh_rsp_data | output | BH_DATA_W | Blackhole read data, all ones |

## Verification
The bench builds two copies of the block with the same stimulus. One copy uses `FEATURE_EN` = 1, which makes the whole query, answer and lock sequence reachable, including a reset while the register sits in the answered state. The other uses `FEATURE_EN` = 0, which lets every write pattern be checked for having no effect. Both use the default 8-bit register and 32-bit blackhole data, so the query code 0xFF and lock bit 1 are exercised exactly as stated. The blackhole responder is driven with the response side stalled for several cycles and with back-to-back requests.

// File: rtl/smbase_pkg.sv
package smbase_pkg;
  typedef enum logic [1:0] {
    SMB_OPEN     = 2'd0,
    SMB_ANSWERED = 2'd1,
    SMB_LOCKED   = 2'd2
  } smb_state_e;

  localparam int unsigned SMB_LOCK_BIT = 1;
  localparam int unsigned SMB_PRESENT_VAL = 1;
endpackage

// File: rtl/smbase_reg_core.sv
module smbase_reg_core
  import smbase_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);
  localparam logic [DATA_W-1:0] QUERY_CODE   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] PRESENT_CODE = DATA_W'(SMB_PRESENT_VAL);
  localparam logic [DATA_W-1:0] LOCK_CODE    = DATA_W'(1) << SMB_LOCK_BIT;

  smb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SMB_OPEN:     if (wr_valid && wr_data == QUERY_CODE) state_d = SMB_ANSWERED;
      SMB_ANSWERED: if (wr_valid && wr_data[SMB_LOCK_BIT]) state_d = SMB_LOCKED;
      SMB_LOCKED:   state_d = SMB_LOCKED;
      default:      state_d = SMB_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SMB_OPEN;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      SMB_ANSWERED: rd_data = PRESENT_CODE;
      SMB_LOCKED:   rd_data = LOCK_CODE;
      default:      rd_data = '0;
    endcase
  end

  assign locked = (state_q == SMB_LOCKED);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && rd_data == LOCK_CODE);

  assert_unqueried_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0 && wr_valid && wr_data != QUERY_CODE) |=> rd_data == '0);

  assert_query_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0 && wr_valid && wr_data == QUERY_CODE) |=> rd_data == PRESENT_CODE);

  assert_readback_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_data));
endmodule

// File: rtl/smbase_bh_resp.sv
module smbase_bh_resp #(
  parameter int unsigned BH_DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [BH_DATA_W-1:0] rsp_data
);
  logic pend_q;

  assign req_ready = !pend_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (req_valid && req_ready) pend_q <= 1'b1;
    else if (rsp_ready)              pend_q <= 1'b0;
  end

  assign rsp_valid = pend_q;
  assign rsp_data  = {BH_DATA_W{1'b1}};

  assert_rsp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  assert_req_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid && rsp_data == {BH_DATA_W{1'b1}});
endmodule

// File: rtl/smbase_lock_reg.sv
module smbase_lock_reg #(
  parameter bit          FEATURE_EN = 1'b1,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BH_DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_valid,
  output logic                 cfg_wr_ready,
  input  logic [DATA_W-1:0]    cfg_wr_data,
  output logic [DATA_W-1:0]    cfg_rd_data,
  output logic                 bh_en,
  output logic                 smm_win_en,
  input  logic                 bh_req_valid,
  output logic                 bh_req_ready,
  output logic                 bh_rsp_valid,
  input  logic                 bh_rsp_ready,
  output logic [BH_DATA_W-1:0] bh_rsp_data
);
  localparam int unsigned LOCK_POS = smbase_pkg::SMB_LOCK_BIT;

  assign cfg_wr_ready = 1'b1;

  generate
    if (FEATURE_EN) begin : g_on
      logic locked;
      smbase_reg_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (cfg_wr_valid),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .locked   (locked)
      );
      assign bh_en      = locked;
      assign smm_win_en = locked;
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{cfg_wr_valid, cfg_wr_data};
      assign cfg_rd_data   = '0;
      assign bh_en         = 1'b0;
      assign smm_win_en    = 1'b0;
    end
  endgenerate

  smbase_bh_resp #(.BH_DATA_W(BH_DATA_W)) u_bh (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (bh_req_valid),
    .req_ready (bh_req_ready),
    .rsp_valid (bh_rsp_valid),
    .rsp_ready (bh_rsp_ready),
    .rsp_data  (bh_rsp_data)
  );

  assert_enable_on_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bh_en) |-> $past(cfg_wr_valid && cfg_wr_data[LOCK_POS]));

  assert_enables_follow_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smm_win_en |-> cfg_rd_data[LOCK_POS]);

  always_comb begin
    if (!FEATURE_EN) begin
      assert_disabled_quiet_R7: assert (cfg_rd_data == '0 && !bh_en && !smm_win_en);
    end
  end
endmodule

// File: tb/tb_smbase_lock_reg.sv
module tb_smbase_lock_reg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0;
  logic [7:0]  wd = '0;
  logic        rqv = 1'b0;
  logic        rsr = 1'b1;

  logic        wr_rdy, bh, smm, rq_rdy, rs_v;
  logic [7:0]  rd;
  logic [31:0] rs_d;
  logic        wr_rdy_o, bh_o, smm_o, rq_rdy_o, rs_v_o;
  logic [7:0]  rd_o;
  logic [31:0] rs_d_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  smbase_lock_reg #(.FEATURE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(wv), .cfg_wr_ready(wr_rdy),
    .cfg_wr_data(wd), .cfg_rd_data(rd), .bh_en(bh), .smm_win_en(smm),
    .bh_req_valid(rqv), .bh_req_ready(rq_rdy), .bh_rsp_valid(rs_v),
    .bh_rsp_ready(rsr), .bh_rsp_data(rs_d));

  smbase_lock_reg #(.FEATURE_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(wv), .cfg_wr_ready(wr_rdy_o),
    .cfg_wr_data(wd), .cfg_rd_data(rd_o), .bh_en(bh_o), .smm_win_en(smm_o),
    .bh_req_valid(rqv), .bh_req_ready(rq_rdy_o), .bh_rsp_valid(rs_v_o),
    .bh_rsp_ready(rsr), .bh_rsp_data(rs_d_o));

  // behavioural reference: value plus write mask, updated per clock
  int m_val = 0;
  int m_mask = 255;
  bit m_pend = 1'b0;

  always @(posedge clk) begin
    int nv;
    bit rdy;
    rdy = !m_pend || rsr;
    if (!rst_n) begin
      m_val = 0; m_mask = 255; m_pend = 1'b0;
    end else begin
      if (wv) begin
        nv = (m_val & ~m_mask & 255) | (int'(wd) & m_mask);
        if (nv == 255) begin
          m_mask = 2; nv = 1;
        end else begin
          if (m_mask == 255) nv = 0;
          if ((nv & 2) != 0) begin
            m_mask = m_mask & ~2; nv = 2;
          end
        end
        m_val = nv;
      end
      if (rqv && rdy) m_pend = 1'b1;
      else if (rsr)   m_pend = 1'b0;
    end
  end

  task automatic cmp(input string t, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit lk;
    lk = (m_val & 2) != 0;
    cmp(tag, "read data", rd, m_val);
    cmp(tag, "blackhole enable", bh, lk);
    cmp(tag, "smm window enable", smm, lk);
    cmp("R10", "write ready", wr_rdy, 1);
    cmp("R8", "request ready", rq_rdy, !m_pend || rsr);
    cmp("R8", "response valid", rs_v, m_pend);
    if (rs_v) cmp("R8", "response data", rs_d, 32'hFFFF_FFFF);
    cmp("R7", "disabled read data", rd_o, 0);
    cmp("R7", "disabled blackhole enable", bh_o, 0);
    cmp("R7", "disabled smm enable", smm_o, 0);
  end

  task automatic step(input bit v, input logic [7:0] d);
    @(posedge clk); #1;
    wv = v; wd = d;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d);
    step(1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) step(1'b0, 8'h00);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) step(1'b0, 8'h00);
    tag = "R2";
    wr(8'h02); wr(8'h55); wr(8'hFE);
    tag = "R3";
    wr(8'hFF);
    tag = "R4";
    wr(8'h01); wr(8'h00); wr(8'hFD); wr(8'h80);
    tag = "R5";
    wr(8'h02);
    tag = "R6";
    wr(8'hFF); wr(8'h00); wr(8'h02); wr(8'hFD);
    repeat (2) step(1'b0, 8'h00);
    tag = "R9";
    @(posedge clk); #1; rst_n = 1'b0;
    step(1'b0, 8'h00);
    @(posedge clk); #1; rst_n = 1'b1;
    wr(8'hFF);
    @(posedge clk); #1; rst_n = 1'b0;
    step(1'b0, 8'h00);
    @(posedge clk); #1; rst_n = 1'b1;
    wr(8'h02);
    wr(8'hFF); wr(8'h06);
    tag = "R8";
    @(posedge clk); #1; rsr = 1'b0; rqv = 1'b1;
    @(posedge clk); #1; rqv = 1'b0;
    repeat (3) @(posedge clk);
    #1; rsr = 1'b1; rqv = 1'b1;
    repeat (3) @(posedge clk);
    #1; rqv = 1'b0;
    repeat (3) step(1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule